// File: doc/BRIEF.md
# Per-Bunch Turn-Delay and Two-Tap Difference Filter

This block sits in the digital path of a bunch-by-bunch feedback loop for a storage ring. Every clock cycle it may accept one 8-bit position sample, tagged with the index of the bunch slot it belongs to. Each bunch has its own circular history of past turns. The block keeps this history twice, in two independent arrays, so that two taps can be read in the same cycle. For every accepted sample it returns one correction sample for the same bunch. In delay mode the correction is a plain copy of the sample that bunch gave a set number of turns earlier. In two-tap mode it is the difference of two such past samples. The difference removes any constant offset on the bunch signal.

A revolution marker tells the block where a new turn starts. The first sample of a bunch after a marker opens a new history slot for that bunch. A further sample of the same bunch before the next marker replaces the value in the slot of the current turn. A small register port holds the mode and the two tap offsets. All samples use offset binary, where 0x80 stands for zero. The number of bunch slots and the history depth are parameters. A full ring uses about 5120 slots, and the default is kept small.

Top module: `bunch_fb_filter`

## Requirements
- R1: During reset and right after it, out_valid is low and out_sample is 0x80.
- R2: Each accepted sample (in_valid high at a rising edge) gives exactly one output, with out_valid high two clock cycles later. Outputs keep the order of the inputs, and out_bunch repeats the input bunch index.
- R3: In delay mode (mode bit 0 = 0), out_sample equals the sample the same bunch gave tap-A turns earlier.
- R4: In two-tap mode (mode bit 0 = 1), the output is the tap-B sample minus the tap-A sample. The result is saturated to the range -128..+127 and presented with 0x80 added, modulo 256. A difference of +255 gives 0xFF and a difference of -255 gives 0x00.
- R5: In two-tap mode, a bunch fed a constant value produces 0x80 once both taps reach valid history.
- R6: The output is 0x80 while the bunch has fewer earlier turns stored than a needed tap offset. Delay mode needs tap A. Two-tap mode needs both tap A and tap B.
- R7: A tap offset written as 0 acts as 1. An offset above DEPTH acts as DEPTH.
- R8: Bunches are independent. A sample of one bunch never changes the history of another bunch.
- R9: Each bunch's history slot pointer wraps modulo DEPTH. With a tap of DEPTH, the output is the sample from exactly DEPTH turns earlier.
- R10: The config registers are written when cfg_we is high. Address 0 bit 0 is the mode, address 1 is tap A and address 2 is tap B. A write affects samples accepted from the next cycle on.
- R11: turn_mark starts a new turn, and it applies to a sample accepted in the same cycle. A second sample of a bunch within one turn overwrites that turn's slot and does not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Position sample, offset binary |
| in_bunch | input | BUNCH_IDX_W | Bunch slot index of the sample |
| turn_mark | input | 1 | Revolution marker, starts a new turn |
| cfg_we | input | 1 | Config register write enable |
| cfg_addr | input | 2 | Config register select |
| cfg_wdata | input | CFG_W | Config write data |
| out_valid | output | 1 | Correction sample strobe |
| out_sample | output | SAMPLE_W | Correction sample, offset binary |
| out_bunch | output | BUNCH_IDX_W | Bunch index of the correction sample |

## Verification
The assertions assume that in_valid is low and in_bunch stays below NUM_BUNCH throughout reset. Under that assumption, the two-cycle strobe and index echo can be compared with the inputs from the first edge after reset. They also assume that config data reaches the taps only through the clamp, so the tap offsets always stay within 1 to DEPTH. The stimulus holds in_valid low during reset and draws bunch indices only below NUM_BUNCH. It deliberately writes offsets of 0 and 200 so that the clamp is exercised. The stimulus also randomizes idle cycles and marker placement, so that both the new-turn path and the overwrite path are exercised.

// File: rtl/bfb_pkg.sv
package bfb_pkg;

   typedef enum logic {
      FB_MODE_DELAY  = 1'b0,
      FB_MODE_TWOTAP = 1'b1
   } fb_mode_e;

   localparam logic [1:0] CFG_SEL_MODE = 2'd0;
   localparam logic [1:0] CFG_SEL_TAPA = 2'd1;
   localparam logic [1:0] CFG_SEL_TAPB = 2'd2;

   localparam int NUM_TAPS = 2;

endpackage

// File: rtl/bfb_cfg.sv
module bfb_cfg
   import bfb_pkg::*;
#(
   parameter int DEPTH = 100,
   parameter int CFG_W = 8,
   parameter int TAP_W = 7
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [1:0]                        cfg_addr,
   input  logic [CFG_W-1:0]                  cfg_wdata,
   output fb_mode_e                          mode,
   output logic [NUM_TAPS-1:0][TAP_W-1:0]    tap_eff
);

   logic [NUM_TAPS-1:0][CFG_W-1:0] tap_raw_q;
   fb_mode_e                       mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= FB_MODE_DELAY;
         tap_raw_q <= {NUM_TAPS{CFG_W'(1)}};
      end else if (cfg_we) begin
         case (cfg_addr)
            CFG_SEL_MODE: mode_q       <= fb_mode_e'(cfg_wdata[0]);
            CFG_SEL_TAPA: tap_raw_q[0] <= cfg_wdata;
            CFG_SEL_TAPB: tap_raw_q[1] <= cfg_wdata;
            default:      ;
         endcase
      end
   end

   assign mode = mode_q;

   // Clamp each raw offset into 1..DEPTH
   for (genvar gt = 0; gt < NUM_TAPS; gt++) begin : g_clamp
      always_comb begin
         if (tap_raw_q[gt] == '0)
            tap_eff[gt] = TAP_W'(1);
         else if (tap_raw_q[gt] > CFG_W'(DEPTH))
            tap_eff[gt] = TAP_W'(DEPTH);
         else
            tap_eff[gt] = tap_raw_q[gt][TAP_W-1:0];
      end
   end

   if (CFG_W < TAP_W) begin : g_bad_cfgw
      $error("bfb_cfg: CFG_W must hold DEPTH");
   end

endmodule

// File: rtl/bfb_hist_ctl.sv
module bfb_hist_ctl
   import bfb_pkg::*;
#(
   parameter int NUM_BUNCH = 8,
   parameter int DEPTH     = 100,
   parameter int BW        = 3,
   parameter int AW        = 10,
   parameter int TAP_W     = 7
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [BW-1:0]                  in_bunch,
   input  logic                           turn_mark,
   input  fb_mode_e                       mode,
   input  logic [NUM_TAPS-1:0][TAP_W-1:0] tap_eff,
   output logic                           wr_en,
   output logic [AW-1:0]                  wr_addr,
   output logic [NUM_TAPS-1:0][AW-1:0]    rd_addr,
   output logic                           s1_valid,
   output logic [BW-1:0]                  s1_bunch,
   output fb_mode_e                       s1_mode,
   output logic [NUM_TAPS-1:0]            s1_have
);

   localparam int SW = $clog2(DEPTH);

   logic [SW-1:0]        ptr_q  [NUM_BUNCH];
   logic [TAP_W-1:0]     fill_q [NUM_BUNCH];
   logic [NUM_BUNCH-1:0] armed_q;

   logic                 new_turn;
   logic [SW-1:0]        cur_ptr;
   logic [SW-1:0]        ptr_new;
   logic [TAP_W-1:0]     cur_fill;
   logic [TAP_W-1:0]     fill_before;
   logic [TAP_W-1:0]     fill_next;
   logic [AW-1:0]        base;
   logic [NUM_TAPS-1:0]  have;

   always_comb begin
      cur_ptr     = ptr_q[in_bunch];
      cur_fill    = fill_q[in_bunch];
      new_turn    = armed_q[in_bunch] | turn_mark;
      if (!new_turn)
         ptr_new = cur_ptr;
      else if (cur_ptr == SW'(DEPTH - 1))
         ptr_new = '0;
      else
         ptr_new = cur_ptr + SW'(1);
      fill_before = new_turn ? cur_fill : cur_fill - TAP_W'(1);
      fill_next   = (cur_fill == TAP_W'(DEPTH)) ? cur_fill : cur_fill + TAP_W'(1);
      base        = AW'(in_bunch) * AW'(DEPTH);
   end

   assign wr_en   = in_valid;
   assign wr_addr = base + AW'(ptr_new);

   // One circular read address per tap
   for (genvar gt = 0; gt < NUM_TAPS; gt++) begin : g_tap
      logic [SW:0]   back_sum;
      logic [SW-1:0] rd_slot;
      always_comb begin
         back_sum = {1'b0, ptr_new} + (SW+1)'(DEPTH) - (SW+1)'(tap_eff[gt]);
         if (back_sum >= (SW+1)'(DEPTH))
            rd_slot = SW'(back_sum - (SW+1)'(DEPTH));
         else
            rd_slot = back_sum[SW-1:0];
      end
      assign rd_addr[gt] = base + AW'(rd_slot);
      assign have[gt]    = (fill_before >= tap_eff[gt]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BUNCH; b++) begin
            ptr_q[b]  <= SW'(DEPTH - 1);
            fill_q[b] <= '0;
         end
         armed_q <= '1;
      end else begin
         if (turn_mark)
            armed_q <= '1;
         if (in_valid && new_turn) begin
            ptr_q[in_bunch]   <= ptr_new;
            fill_q[in_bunch]  <= fill_next;
            armed_q[in_bunch] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_bunch <= '0;
         s1_mode  <= FB_MODE_DELAY;
         s1_have  <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_bunch <= in_bunch;
         s1_mode  <= mode;
         s1_have  <= have;
      end
   end

endmodule

// File: rtl/bfb_tap_ram.sv
module bfb_tap_ram #(
   parameter int ENTRIES = 800,
   parameter int AW      = 10,
   parameter int W       = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra,
   output logic [W-1:0]  rd
);

   logic [W-1:0] mem [ENTRIES];

   // Read-first: a read of the slot being written returns the old value
   always_ff @(posedge clk) begin
      if (we)
         mem[wa] <= wd;
      rd <= mem[ra];
   end

endmodule

// File: rtl/bfb_combine.sv
module bfb_combine
   import bfb_pkg::*;
#(
   parameter int W  = 8,
   parameter int BW = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          s1_valid,
   input  logic [BW-1:0]                 s1_bunch,
   input  fb_mode_e                      s1_mode,
   input  logic [NUM_TAPS-1:0]           s1_have,
   input  logic [NUM_TAPS-1:0][W-1:0]    tap_q,
   output logic                          out_valid,
   output logic [W-1:0]                  out_sample,
   output logic [BW-1:0]                 out_bunch
);

   localparam logic [W-1:0] ZERO_CODE = {1'b1, {(W-1){1'b0}}};
   localparam logic signed [W:0] POS_MAX = (W+1)'((1 << (W-1)) - 1);
   localparam logic signed [W:0] NEG_MIN = -(W+1)'(1 << (W-1));

   logic signed [W:0] diff;
   logic signed [W:0] clipped;
   logic [W-1:0]      twotap_code;
   logic [W-1:0]      result;

   always_comb begin
      diff = $signed({1'b0, tap_q[1]}) - $signed({1'b0, tap_q[0]});
      if (diff > POS_MAX)
         clipped = POS_MAX;
      else if (diff < NEG_MIN)
         clipped = NEG_MIN;
      else
         clipped = diff;
      twotap_code = {~clipped[W-1], clipped[W-2:0]};
      if (s1_mode == FB_MODE_TWOTAP)
         result = (&s1_have) ? twotap_code : ZERO_CODE;
      else
         result = s1_have[0] ? tap_q[0] : ZERO_CODE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= ZERO_CODE;
         out_bunch  <= '0;
      end else begin
         out_valid  <= s1_valid;
         out_sample <= result;
         out_bunch  <= s1_bunch;
      end
   end

endmodule

// File: rtl/bunch_fb_filter.sv
module bunch_fb_filter
   import bfb_pkg::*;
#(
   parameter int NUM_BUNCH   = 8,
   parameter int DEPTH       = 100,
   parameter int SAMPLE_W    = 8,
   parameter int CFG_W       = 8,
   parameter int BUNCH_IDX_W = $clog2(NUM_BUNCH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [SAMPLE_W-1:0]    in_sample,
   input  logic [BUNCH_IDX_W-1:0] in_bunch,
   input  logic                   turn_mark,
   input  logic                   cfg_we,
   input  logic [1:0]             cfg_addr,
   input  logic [CFG_W-1:0]       cfg_wdata,
   output logic                   out_valid,
   output logic [SAMPLE_W-1:0]    out_sample,
   output logic [BUNCH_IDX_W-1:0] out_bunch
);

   localparam int TAP_W   = $clog2(DEPTH + 1);
   localparam int ENTRIES = NUM_BUNCH * DEPTH;
   localparam int AW      = $clog2(ENTRIES);

   if (NUM_BUNCH < 2) begin : g_bad_nb
      $error("bunch_fb_filter: NUM_BUNCH must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("bunch_fb_filter: DEPTH must be at least 2");
   end
   if (SAMPLE_W < 2) begin : g_bad_w
      $error("bunch_fb_filter: SAMPLE_W must be at least 2");
   end
   if (BUNCH_IDX_W < $clog2(NUM_BUNCH)) begin : g_bad_bw
      $error("bunch_fb_filter: BUNCH_IDX_W too narrow");
   end

   fb_mode_e                              mode;
   logic [NUM_TAPS-1:0][TAP_W-1:0]        tap_eff;
   logic                                  wr_en;
   logic [AW-1:0]                         wr_addr;
   logic [NUM_TAPS-1:0][AW-1:0]           rd_addr;
   logic [NUM_TAPS-1:0][SAMPLE_W-1:0]     tap_q;
   logic                                  s1_valid;
   logic [BUNCH_IDX_W-1:0]                s1_bunch;
   fb_mode_e                              s1_mode;
   logic [NUM_TAPS-1:0]                   s1_have;

   bfb_cfg #(
      .DEPTH (DEPTH),
      .CFG_W (CFG_W),
      .TAP_W (TAP_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .mode      (mode),
      .tap_eff   (tap_eff)
   );

   bfb_hist_ctl #(
      .NUM_BUNCH (NUM_BUNCH),
      .DEPTH     (DEPTH),
      .BW        (BUNCH_IDX_W),
      .AW        (AW),
      .TAP_W     (TAP_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_bunch  (in_bunch),
      .turn_mark (turn_mark),
      .mode      (mode),
      .tap_eff   (tap_eff),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr),
      .s1_valid  (s1_valid),
      .s1_bunch  (s1_bunch),
      .s1_mode   (s1_mode),
      .s1_have   (s1_have)
   );

   // Array A feeds tap index 0, array B feeds tap index 1
   for (genvar gt = 0; gt < NUM_TAPS; gt++) begin : g_arr
      bfb_tap_ram #(
         .ENTRIES (ENTRIES),
         .AW      (AW),
         .W       (SAMPLE_W)
      ) u_ram (
         .clk (clk),
         .we  (wr_en),
         .wa  (wr_addr),
         .wd  (in_sample),
         .ra  (rd_addr[gt]),
         .rd  (tap_q[gt])
      );
   end

   bfb_combine #(
      .W  (SAMPLE_W),
      .BW (BUNCH_IDX_W)
   ) u_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .s1_valid   (s1_valid),
      .s1_bunch   (s1_bunch),
      .s1_mode    (s1_mode),
      .s1_have    (s1_have),
      .tap_q      (tap_q),
      .out_valid  (out_valid),
      .out_sample (out_sample),
      .out_bunch  (out_bunch)
   );

endmodule

// File: rtl/bfb_chk.sv
module bfb_chk #(
   parameter int DEPTH = 100,
   parameter int BW    = 3,
   parameter int TAP_W = 7,
   parameter int W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [BW-1:0]    in_bunch,
   input logic             out_valid,
   input logic [W-1:0]     out_sample,
   input logic [BW-1:0]    out_bunch,
   input logic [TAP_W-1:0] tap_a,
   input logic [TAP_W-1:0] tap_b
);

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && out_sample == {1'b1, {(W-1){1'b0}}}));

   assert_strobe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

   assert_bunch_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_bunch == $past(in_bunch, 2));

   assert_tap_a_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_a >= TAP_W'(1)) && (tap_a <= TAP_W'(DEPTH)));

   assert_tap_b_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_b >= TAP_W'(1)) && (tap_b <= TAP_W'(DEPTH)));

endmodule

bind bunch_fb_filter bfb_chk #(
   .DEPTH (DEPTH),
   .BW    (BUNCH_IDX_W),
   .TAP_W (TAP_W),
   .W     (SAMPLE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_bunch   (in_bunch),
   .out_valid  (out_valid),
   .out_sample (out_sample),
   .out_bunch  (out_bunch),
   .tap_a      (tap_eff[0]),
   .tap_b      (tap_eff[1])
);

// File: tb/sim_bunch_fb_filter.sv
module sim_bunch_fb_filter;

   localparam int NB = 8;
   localparam int D  = 100;
   localparam int BW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_sample = '0;
   logic [BW-1:0] in_bunch = '0;
   logic          turn_mark = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_addr = '0;
   logic [7:0]    cfg_wdata = '0;
   logic          out_valid;
   logic [7:0]    out_sample;
   logic [BW-1:0] out_bunch;

   bunch_fb_filter #(.NUM_BUNCH(NB), .DEPTH(D), .SAMPLE_W(8), .CFG_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_bunch(in_bunch), .turn_mark(turn_mark), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
      .out_sample(out_sample), .out_bunch(out_bunch));

   always #5 clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   bit done     = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   // Reference model state
   int  hist  [NB][D];
   int  ptr   [NB];
   int  fill  [NB];
   bit  armed [NB];
   int  m_mode = 0;
   int  m_raw_a = 1;
   int  m_raw_b = 1;
   string tag = "R1";

   int    q_val[$];
   int    q_bunch[$];
   int    q_cyc[$];
   string q_tag[$];

   task automatic check(input bit ok, input string t, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", t, act, exp, cyc);
      end
   endtask

   function automatic int clampk(input int raw);
      if (raw == 0) return 1;
      if (raw > D) return D;
      return raw;
   endfunction

   function automatic int satcode(input int d);
      int c;
      c = d;
      if (c > 127) c = 127;
      if (c < -128) c = -128;
      return c + 128;
   endfunction

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin
         ptr[b] = D - 1; fill[b] = 0; armed[b] = 1'b1;
      end
      m_mode = 0; m_raw_a = 1; m_raw_b = 1;
   endtask

   task automatic model_sample(input int b, input int s, input bit mark, output int exp);
      bit nt;
      int p, fb, ka, kb, va, vb;
      if (mark)
         for (int i = 0; i < NB; i++) armed[i] = 1'b1;
      nt = armed[b];
      p  = nt ? (ptr[b] + 1) % D : ptr[b];
      fb = nt ? fill[b] : fill[b] - 1;
      ka = clampk(m_raw_a);
      kb = clampk(m_raw_b);
      va = hist[b][(p + D - ka) % D];
      vb = hist[b][(p + D - kb) % D];
      if (m_mode == 0)
         exp = (fb >= ka) ? va : 128;
      else
         exp = (fb >= ka && fb >= kb) ? satcode(vb - va) : 128;
      hist[b][p] = s;
      if (nt) begin
         ptr[b] = p;
         fill[b] = (fill[b] < D) ? fill[b] + 1 : D;
         armed[b] = 1'b0;
      end
   endtask

   task automatic send(input int b, input int s, input bit mark);
      int e;
      @(negedge clk);
      cfg_we    = 1'b0;
      in_valid  = 1'b1;
      in_bunch  = BW'(b);
      in_sample = 8'(s);
      turn_mark = mark;
      model_sample(b, s, mark, e);
      q_val.push_back(e);
      q_bunch.push_back(b);
      q_cyc.push_back(cyc + 2);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; turn_mark = 1'b0; cfg_we = 1'b0;
      end
   endtask

   // R10: register map, address 0 mode bit 0, address 1 tap A, address 2 tap B
   task automatic cfg_write(input int a, input int d);
      @(negedge clk);
      in_valid = 1'b0; turn_mark = 1'b0;
      cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
      if (a == 0) m_mode = d & 1;
      if (a == 1) m_raw_a = d;
      if (a == 2) m_raw_b = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_turns(input int nturns, input int const_b, input int const_v,
                            input bit gaps);
      for (int t = 0; t < nturns; t++)
         for (int b = 0; b < NB; b++) begin
            if (gaps && ($urandom % 4 == 0)) idle(1);
            send(b, (b == const_b) ? const_v : int'($urandom % 256), b == 0);
         end
   endtask

   // Output checker: order, latency, bunch index and value (R2 plus phase tags)
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (q_val.size() == 0) begin
            check(1'b0, "R2 unexpected output", 1, 0);
         end else begin
            int ev, eb, ec;
            string et;
            ev = q_val.pop_front(); eb = q_bunch.pop_front();
            ec = q_cyc.pop_front(); et = q_tag.pop_front();
            check(ec == cyc, "R2 latency", cyc, ec);
            check(int'(out_bunch) == eb, "R2 bunch order", int'(out_bunch), eb);
            check(int'(out_sample) == ev, et, int'(out_sample), ev);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         check(1'b0, "watchdog", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c1a));
      model_reset();
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(out_sample == 8'h80, "R1 sample after reset", int'(out_sample), 128);

      // Delay mode, tap A = 3 (R3, R6, R8, R10)
      tag = "R3/R6/R8/R10 delay";
      cfg_write(0, 0);
      cfg_write(1, 3);
      run_turns(8, -1, 0, 1'b1);

      // Two-tap, A=1, B=4, bunch 2 constant (R4, R5, R8)
      tag = "R5/R4/R8 two-tap";
      cfg_write(0, 1);
      cfg_write(1, 1);
      cfg_write(2, 4);
      run_turns(8, 2, 'h5a, 1'b1);

      // Saturation with alternating extremes (R4)
      tag = "R4 saturation";
      cfg_write(2, 2);
      for (int t = 0; t < 6; t++)
         for (int b = 0; b < NB; b++) send(b, (t % 2 == 0) ? 'h00 : 'hff, b == 0);

      // Clamp: 0 acts as 1, 200 acts as DEPTH; pointer wrap (R7, R9)
      tag = "R7 clamp low";
      cfg_write(0, 0);
      cfg_write(1, 0);
      run_turns(3, -1, 0, 1'b1);
      tag = "R7/R9 clamp high and wrap";
      cfg_write(1, 200);
      run_turns(104, -1, 0, 1'b0);

      // Marker placement and same-turn overwrite (R11)
      tag = "R11 directed overwrite";
      cfg_write(1, 1);
      send(3, 'h11, 1'b1);
      send(3, 'h22, 1'b0);
      send(5, 'h33, 1'b0);
      send(3, 'h44, 1'b1);
      idle(2);
      tag = "R11 random markers";
      for (int i = 0; i < 300; i++) begin
         if (i == 150) cfg_write(0, 1);
         if ($urandom % 5 == 0) idle(1);
         send(int'($urandom % NB), int'($urandom % 256), ($urandom % 6) == 0);
      end
      idle(6);

      check(q_val.size() == 0, "R2 all outputs delivered", q_val.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule